// File: doc/BRIEF.md
# TDM Frame Ratio and Sample-Rate Detector

This block watches the bit clock and frame sync of a TDM or I2S audio bus and works out the frame shape and the sample rate without any programming. Every frame it counts bit-clock rising edges between two frame-sync rising edges. That count is the clock-to-sync ratio, and it fixes the slot count and slot width. In the same frame it counts cycles of a free-running reference clock, which gives the frame period. The period is then sorted into one of six sample-rate families.

Both bus signals pass through simple synchronizers into the reference-clock domain. The block reports a new classification only after the same (rate, ratio) pair has been seen in several frames in a row. A valid flag shows that the reported pair is a real, error-free classification. If the frame sync goes silent for longer than any legal frame, the flag drops and the block starts to acquire again.

Top module: `tdm_frame_sense`

## Requirements
- R1: While reset is asserted, and after it until the first commit, rate_code is 3'b100, ratio_code is 4'h6 and class_valid is 0.
- R2: The bit-clock rising edges counted from one frame-sync rise up to the next give ratio_code as follows: 32→0, 48→1, 64→2, 96→3, 128→4, 192→5, 256→6, 384→7, 512→8.
- R3: Any other count per frame gives ratio_code 4'hF, and the committed class_valid is then 0.
- R4: With P = FRAME48_CYC, the nominal frame periods in reference cycles are 3P (code 1), 2P (code 2), 3P/2 (code 3), P (code 4), P/2 (code 5) and P/4 (code 6). Each family also has a second nominal, equal to the first times 160/147, for the 44.1 kHz-based rates. A period near either nominal gives that code.
- R5: A measured period N matches a nominal M only when 97·M ≤ 100·N ≤ 103·M. For P = 512 this means 497 and 527 give code 4, while 496 and 528 do not.
- R6: A period outside every window gives rate_code 3'b111 with class_valid 0. rate_code is never 3'b000.
- R7: A pair is committed only when CONFIRM (default 4) consecutive measured frames give the same pair. The first frame-sync rise after reset or after a silence only starts measurement.
- R8: Between commits, rate_code and ratio_code hold their values. After a bus change, the old codes remain for three new frames and the new codes appear after the fourth.
- R9: If no frame-sync rise arrives within LIMIT reference cycles (LIMIT is just above the longest legal window), class_valid falls, the codes hold, and acquisition restarts as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, at least twice the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_bclk | input | 1 | Audio bus bit clock (asynchronous) |
| bus_fsync | input | 1 | Audio bus frame sync (asynchronous) |
| rate_code | output | 3 | Committed sample-rate family code |
| ratio_code | output | 4 | Committed bit-clocks-per-frame code |
| class_valid | output | 1 | Committed pair is error-free and the bus is alive |

## Verification
The hardest cases to reach from the ports are the edges of the period windows and a bit clock running right at the synchronizer limit. Both need frame periods and edge counts that are exact to one reference cycle. The bench therefore builds each frame from the reference clock. It places bit-clock edges with an integer phase formula, so that any ratio fits exactly into any frame length, including one bit-clock half-period per reference cycle. This allows periods of 496, 497, 527 and 528 cycles to be produced exactly. It also allows the nine ratios and twelve rate nominals to be swept, with the confirmation delay checked one frame before and one frame after the commit.

// File: rtl/tdmfs_pkg.sv
`timescale 1ns/1ps
package tdmfs_pkg;
  localparam int unsigned RATIO_KINDS = 9;
  localparam logic [2:0]  RATE_ERR  = 3'b111;
  localparam logic [2:0]  RATE_RST  = 3'b100;
  localparam logic [3:0]  RATIO_ERR = 4'hF;
  localparam logic [3:0]  RATIO_RST = 4'h6;

  typedef struct packed {
    logic [2:0] rate;
    logic [3:0] ratio;
  } frame_class_t;

  // Legal bit-clocks per frame for ratio index idx: 32,48,64,96,...
  function automatic int unsigned ratio_of_code(int unsigned idx);
    return (((idx % 2) == 0) ? 32 : 48) << (idx / 2);
  endfunction

  function automatic logic [3:0] ratio_classify(int unsigned bits);
    logic [3:0] r;
    r = RATIO_ERR;
    for (int unsigned i = 0; i < RATIO_KINDS; i++)
      if (bits == ratio_of_code(i)) r = 4'(i);
    return r;
  endfunction

  // Nominal frame period in reference cycles for a rate family
  function automatic int unsigned rate_nominal(int unsigned base48, logic [2:0] code,
                                               logic series44);
    int unsigned n;
    case (code)
      3'd1:    n = base48 * 3;
      3'd2:    n = base48 * 2;
      3'd3:    n = base48 * 3 / 2;
      3'd5:    n = base48 / 2;
      3'd6:    n = base48 / 4;
      default: n = base48;
    endcase
    if (series44) n = n * 160 / 147;
    return n;
  endfunction

  function automatic logic in_window(int unsigned per, int unsigned nom);
    return (per * 100 >= nom * 97) && (per * 100 <= nom * 103);
  endfunction

  function automatic logic [2:0] rate_classify(int unsigned per, int unsigned base48);
    logic [2:0] r;
    r = RATE_ERR;
    for (int c = 1; c <= 6; c++)
      for (int s = 0; s < 2; s++)
        if (in_window(per, rate_nominal(base48, 3'(c), 1'(s)))) r = 3'(c);
    return r;
  endfunction

  function automatic int unsigned silence_limit(int unsigned base48);
    return rate_nominal(base48, 3'd1, 1'b1) * 103 / 100 + 1;
  endfunction
endpackage

// File: rtl/tdmfs_edge_sync.sv
`timescale 1ns/1ps
module tdmfs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/tdmfs_frame_meter.sv
`timescale 1ns/1ps
module tdmfs_frame_meter #(
  parameter int unsigned LIMIT = 1722,
  parameter int          PER_W = 11,
  parameter int          BIT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             fs_rise,
  output logic             tick,
  output logic [PER_W-1:0] per,
  output logic [BIT_W-1:0] bits,
  output logic             silence
);
  logic             primed;
  logic [PER_W-1:0] per_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic             at_limit;

  assign at_limit = (per_cnt == PER_W'(LIMIT));
  assign silence  = at_limit & primed & ~fs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      per_cnt <= '0;
      bit_cnt <= '0;
      tick    <= 1'b0;
      per     <= '0;
      bits    <= '0;
    end else if (fs_rise) begin
      per     <= per_cnt + 1'b1;
      bits    <= bit_cnt;
      tick    <= primed;
      primed  <= 1'b1;
      per_cnt <= '0;
      bit_cnt <= bclk_rise ? BIT_W'(1) : '0;
    end else begin
      tick <= 1'b0;
      if (!at_limit) per_cnt <= per_cnt + 1'b1;
      else           primed  <= 1'b0;
      if (bclk_rise && bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tdmfs_confirm.sv
`timescale 1ns/1ps
module tdmfs_confirm
  import tdmfs_pkg::*;
#(
  parameter int unsigned BASE48  = 2048,
  parameter int unsigned CONFIRM = 4,
  parameter int          PER_W   = 13,
  parameter int          BIT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] per,
  input  logic [BIT_W-1:0] bits,
  input  logic             silence,
  output logic [2:0]       rate_code,
  output logic [3:0]       ratio_code,
  output logic             class_valid,
  output logic             commit
);
  localparam int SW = $clog2(CONFIRM + 1);
  localparam logic [SW-1:0] STREAK_TOP = SW'(CONFIRM);

  frame_class_t  cand, last;
  logic [SW-1:0] streak, streak_nx;

  assign cand.rate  = rate_classify(32'(per), BASE48);
  assign cand.ratio = ratio_classify(32'(bits));

  always_comb begin
    if (streak != '0 && cand == last)
      streak_nx = (streak == STREAK_TOP) ? STREAK_TOP : streak + 1'b1;
    else
      streak_nx = SW'(1);
  end

  assign commit = tick && (streak_nx == STREAK_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak      <= '0;
      last        <= '0;
      rate_code   <= RATE_RST;
      ratio_code  <= RATIO_RST;
      class_valid <= 1'b0;
    end else if (silence) begin
      streak      <= '0;
      class_valid <= 1'b0;
    end else if (tick) begin
      streak <= streak_nx;
      last   <= cand;
      if (commit) begin
        rate_code   <= cand.rate;
        ratio_code  <= cand.ratio;
        class_valid <= (cand.rate != RATE_ERR) && (cand.ratio != RATIO_ERR);
      end
    end
  end
endmodule

// File: rtl/tdm_frame_sense.sv
`timescale 1ns/1ps
module tdm_frame_sense
  import tdmfs_pkg::*;
#(
  parameter int unsigned FRAME48_CYC = 2048,
  parameter int unsigned CONFIRM     = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       bus_bclk,
  input  logic       bus_fsync,
  output logic [2:0] rate_code,
  output logic [3:0] ratio_code,
  output logic       class_valid
);
  localparam int unsigned LIMIT = silence_limit(FRAME48_CYC);
  localparam int          PER_W = $clog2(LIMIT + 2);
  localparam int          BIT_W = $clog2(ratio_of_code(RATIO_KINDS - 1)) + 1;

  logic [1:0]       raw_in, rise_evt;
  logic             bclk_rise, fs_rise;
  logic             tick_evt, silence_evt, commit_evt;
  logic [PER_W-1:0] meas_per;
  logic [BIT_W-1:0] meas_bits;

  assign raw_in = {bus_fsync, bus_bclk};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    tdmfs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_ref), .rst_n(rst_n), .din(raw_in[g]), .rise(rise_evt[g])
    );
  end

  assign bclk_rise = rise_evt[0];
  assign fs_rise   = rise_evt[1];

  tdmfs_frame_meter #(.LIMIT(LIMIT), .PER_W(PER_W), .BIT_W(BIT_W)) u_meter (
    .clk(clk_ref), .rst_n(rst_n), .bclk_rise(bclk_rise), .fs_rise(fs_rise),
    .tick(tick_evt), .per(meas_per), .bits(meas_bits), .silence(silence_evt)
  );

  tdmfs_confirm #(.BASE48(FRAME48_CYC), .CONFIRM(CONFIRM), .PER_W(PER_W), .BIT_W(BIT_W)) u_conf (
    .clk(clk_ref), .rst_n(rst_n), .tick(tick_evt), .per(meas_per), .bits(meas_bits),
    .silence(silence_evt), .rate_code(rate_code), .ratio_code(ratio_code),
    .class_valid(class_valid), .commit(commit_evt)
  );
endmodule

// File: rtl/tdm_frame_sense_chk.sv
`timescale 1ns/1ps
module tdm_frame_sense_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [2:0] rate_code,
  input logic [3:0] ratio_code,
  input logic       class_valid,
  input logic       commit,
  input logic       silence
);
  assert_rate_not_reserved_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rate_code != 3'b000);

  assert_ratio_legal_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ratio_code <= 4'd8) || (ratio_code == 4'hF));

  assert_valid_clean_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    class_valid |-> (rate_code != 3'b111) && (ratio_code != 4'hF));

  assert_codes_hold_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !commit |=> $stable(rate_code) && $stable(ratio_code));

  assert_valid_from_commit_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(class_valid) |-> $past(commit));

  assert_silence_drops_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    silence |=> !class_valid);
endmodule

bind tdm_frame_sense tdm_frame_sense_chk u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .rate_code(rate_code), .ratio_code(ratio_code),
  .class_valid(class_valid), .commit(commit_evt), .silence(silence_evt)
);

// File: tb/tdm_frame_sense_test.sv
`timescale 1ns/1ps
module tdm_frame_sense_test;
  localparam int P = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0;
  logic       fsync = 1'b0;
  logic [2:0] rate_code;
  logic [3:0] ratio_code;
  logic       class_valid;
  int         n_checks = 0;
  int         n_fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  tdm_frame_sense #(.FRAME48_CYC(P), .CONFIRM(4), .SYNC_STAGES(2)) uut (
    .clk_ref(clk), .rst_n(rst_n), .bus_bclk(bclk), .bus_fsync(fsync),
    .rate_code(rate_code), .ratio_code(ratio_code), .class_valid(class_valid)
  );

  task automatic check(string tag, logic [2:0] er, logic [3:0] eq, logic ev);
    n_checks++;
    if (rate_code !== er || ratio_code !== eq || class_valid !== ev) begin
      n_fails++;
      $display("FAIL %s: got rate=%b ratio=%h valid=%b, expected rate=%b ratio=%h valid=%b",
               tag, rate_code, ratio_code, class_valid, er, eq, ev);
    end
  endtask

  // Reference cycles i0..i1-1 of a frame of n cycles carrying r bit clocks
  task automatic span(int n, int r, int i0, int i1);
    for (int i = i0; i < i1; i++) begin
      @(negedge clk);
      bclk  = (((2 * r * i) / n) % 2) == 0;
      fsync = (i < n / 4);
    end
  endtask

  task automatic frames(int n, int r, int count);
    for (int k = 0; k < count; k++) span(n, r, 0, n);
  endtask

  // Four full frames, then check in the middle of the fifth, then finish it
  task automatic apply(int n, int r, string tag, logic [2:0] er, logic [3:0] eq, logic ev);
    frames(n, r, 4);
    span(n, r, 0, n / 2);
    check(tag, er, eq, ev);
    span(n, r, n / 2, n);
  endtask

  function automatic int nom48(int c);
    case (c)
      1: return 3 * P;
      2: return 2 * P;
      3: return P + P / 2;
      4: return P;
      5: return P / 2;
      default: return P / 4;
    endcase
  endfunction

  initial begin
    int vals[9] = '{32, 48, 64, 96, 128, 192, 256, 384, 512};
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'b100, 4'h6, 1'b0);
    rst_n = 1'b1;
    // R7: first rise primes; three measurements are not enough
    frames(P, 64, 3);
    span(P, 64, 0, P / 2);
    check("R1/R7 three frames after reset", 3'b100, 4'h6, 1'b0);
    span(P, 64, P / 2, P);
    span(P, 64, 0, P / 2);
    check("R7 fourth measured frame commits", 3'b100, 4'h2, 1'b1);
    span(P, 64, P / 2, P);

    // R2: ratio sweep at the 24 kHz family (frame of 2P cycles)
    for (int k = 0; k < 9; k++)
      apply(2 * P, vals[k], $sformatf("R2 ratio %0d", vals[k]), 3'b010, 4'(k), 1'b1);

    // R3: illegal counts
    apply(P, 40, "R3 ratio 40", 3'b100, 4'hF, 1'b0);
    apply(2 * P, 200, "R3 ratio 200", 3'b010, 4'hF, 1'b0);

    // R4: every family, both series
    for (int c = 1; c <= 6; c++) begin
      int n44;
      apply(nom48(c), 32, $sformatf("R4 family %0d 48-series", c), 3'(c), 4'h0, 1'b1);
      n44 = (nom48(c) * 160 + 73) / 147;
      apply(n44, 32, $sformatf("R4 family %0d 44-series", c), 3'(c), 4'h0, 1'b1);
    end

    // R5/R6: window edges around P
    apply(497, 64, "R5 period 497 inside", 3'b100, 4'h2, 1'b1);
    apply(496, 64, "R5/R6 period 496 outside", 3'b111, 4'h2, 1'b0);
    apply(527, 64, "R5 period 527 inside", 3'b100, 4'h2, 1'b1);
    apply(528, 64, "R5/R6 period 528 outside", 3'b111, 4'h2, 1'b0);
    apply(538, 64, "R6 period 538 in gap", 3'b111, 4'h2, 1'b0);

    // R8: change from P/ratio 64 to 2P/ratio 128
    apply(P, 64, "R8 settle A", 3'b100, 4'h2, 1'b1);
    frames(2 * P, 128, 3);
    span(2 * P, 128, 0, P);
    check("R8 old codes held after three new frames", 3'b100, 4'h2, 1'b1);
    span(2 * P, 128, P, 2 * P);
    span(2 * P, 128, 0, P);
    check("R8 new codes after fourth frame", 3'b010, 4'h4, 1'b1);
    span(2 * P, 128, P, 2 * P);

    // R9: silence longer than the longest window
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      bclk = 1'b0;
      fsync = 1'b0;
    end
    check("R9 silence drops valid, codes held", 3'b010, 4'h4, 1'b0);
    frames(P, 96, 3);
    span(P, 96, 0, P / 2);
    check("R9/R7 reacquire not yet", 3'b010, 4'h4, 1'b0);
    span(P, 96, P / 2, P);
    span(P, 96, 0, P / 2);
    check("R9 reacquired", 3'b100, 4'h3, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule